// File: doc/BRIEF.md
# Hashed Flow Tracking Table

This block keeps a small on-chip table of per-flow state for packets that are candidates for classification. Each request carries a 5-tuple: source address, destination address, source port, destination port and protocol. From the tuple the block derives a 32-bit flow signature and a table index. It then reads the indexed entry and decides how the packet is handled. The packet may be accepted for feature update, it may be the packet that should launch inference, it may collide with another flow that owns the slot, or it may belong to a flow whose class is already known.

A second kind of request, the write-back, uses the same tuple input to store a class result into the entry of the matching flow. A slot held by another flow is only reclaimed when a colliding packet arrives and finds that the owner has been silent for longer than an idle limit. Every table access is a two-cycle read-modify-write. A forwarding register lets requests to the same slot follow each other on consecutive cycles.

Top module: `flow_tracker`

## Requirements
- R1: The signature is a CRC-32 over 13 bytes taken in the order source address, destination address, source port, destination port, protocol, each field most significant byte first. Bits are processed least significant bit first, with reflected polynomial 0xEDB88320, an initial value of all ones and a final inversion. The index is the low IDX_W bits of a CRC-16 over the same bytes, with reflected polynomial 0xA001 and an initial value of zero. Two tuples with equal index and different signature share a slot.
- R2: A packet whose slot is empty, or holds its own signature with class 0, is accepted. Its count rises by one and its timestamp becomes the request time. The result shows status 1 (accept), the new count and class 0.
- R3: The packet count saturates at 255.
- R4: The packet that brings a flow's count to exactly TRIG_COUNT (default 3) reports status 2 (infer). Earlier and later unclassified packets report status 1.
- R5: A packet whose slot holds a different, non-empty signature that is not stale reports status 3 (collide), with count 0 and class 0. The resident entry is left unchanged.
- R6: An entry is stale when the request time minus its stored timestamp, taken modulo 2^32, exceeds IDLE_TICKS (default 60). A difference equal to IDLE_TICKS is not stale. A colliding packet that finds a stale entry takes over the slot with count 1 and class 0, and reports status 1.
- R7: A write-back request whose tuple matches the resident signature stores its class into the entry. A later packet of that flow reports status 4 (classified) with the stored class and unchanged count, and leaves the entry unchanged. A write-back request produces no result.
- R8: A write-back whose signature does not match the resident entry, or whose slot is empty, changes nothing.
- R9: Requests to the same slot on consecutive cycles each see the entry written by the request before.
- R10: After reset every slot is empty and no result is valid. A packet's result appears two clock edges after the edge that samples the request. While no result is valid, status and count read 0. A slot is empty when its signature and count are both zero.
- R11: The timestamp is refreshed by every accepted packet, so staleness is measured from the owner's last accepted packet.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = class write-back, 0 = packet lookup |
| reqTuple | input | 104 | {srcAddr[31:0], dstAddr[31:0], srcPort[15:0], dstPort[15:0], proto[7:0]} |
| reqTime | input | 32 | Arrival timestamp of the packet |
| reqClass | input | 8 | Class value for a write-back |
| resValid | output | 1 | Packet result valid |
| resStatus | output | 3 | 0 none, 1 accept, 2 infer, 3 collide, 4 classified |
| resCount | output | 8 | Packet count of the flow after this packet |
| resClass | output | 8 | Stored class of the flow |

## Verification
A single flow is sent repeatedly, spaced out and back to back. This separates correct counting, the infer position and same-slot forwarding from a stale read. Pairs of tuples that the bench's own CRC model places in one slot bring in collisions. Their timestamps sit just below, at and just above the idle limit, which exposes an off-by-one in the staleness test and a missing timestamp refresh. Matching and non-matching write-backs show that a class lands only on its own flow. A run of 256 packets checks the saturation of the count.

// File: rtl/flow_pkg.sv
package flow_pkg;
  localparam int TUPLE_W = 104;
  localparam int SIG_W   = 32;
  localparam int CLS_W   = 8;
  localparam int CNT_W   = 8;
  localparam int TIME_W  = 32;

  typedef enum logic [2:0] {
    ST_NONE       = 3'd0,
    ST_ACCEPT     = 3'd1,
    ST_INFER      = 3'd2,
    ST_COLLIDE    = 3'd3,
    ST_CLASSIFIED = 3'd4
  } status_e;

  typedef struct packed {
    logic [SIG_W-1:0]  sig;
    logic [CLS_W-1:0]  cls;
    logic [CNT_W-1:0]  cnt;
    logic [TIME_W-1:0] stamp;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrEn;    // write the modified entry back
    logic    claim;   // start a fresh entry for the requesting flow
    logic    bump;    // count plus one (saturating), refresh timestamp
    logic    setCls;  // store the write-back class
    logic    report;  // produce a packet result
    status_e status;
  } strobe_t;

  function automatic logic [31:0] crc32Tuple(input logic [TUPLE_W-1:0] t);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int b = TUPLE_W/8 - 1; b >= 0; b--) begin
      c = c ^ {24'd0, t[b*8 +: 8]};
      for (int k = 0; k < 8; k++)
        c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [15:0] crc16Tuple(input logic [TUPLE_W-1:0] t);
    logic [15:0] c;
    c = 16'h0000;
    for (int b = TUPLE_W/8 - 1; b >= 0; b--) begin
      c = c ^ {8'd0, t[b*8 +: 8]};
      for (int k = 0; k < 8; k++)
        c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/flow_ctrl.sv
module flow_ctrl
  import flow_pkg::*;
#(
  parameter int unsigned IDLE_TICKS = 60,
  parameter int unsigned TRIG_COUNT = 3
) (
  input  logic              s1Valid,
  input  logic              s1Write,
  input  logic [SIG_W-1:0]  s1Sig,
  input  logic [TIME_W-1:0] s1Time,
  input  entry_t            curEntry,
  output strobe_t           strb
);
  localparam logic [CNT_W-1:0]  TRIG_PREV = CNT_W'(TRIG_COUNT - 1);
  localparam logic [TIME_W-1:0] IDLE_LIM  = TIME_W'(IDLE_TICKS);

  logic slotEmpty, sigMatch, slotStale;
  logic [TIME_W-1:0] age;

  always_comb begin
    slotEmpty = (curEntry.sig == '0) && (curEntry.cnt == '0);
    sigMatch  = !slotEmpty && (curEntry.sig == s1Sig);
    age       = s1Time - curEntry.stamp;
    slotStale = age > IDLE_LIM;
  end

  always_comb begin
    strb = '0;
    strb.status = ST_NONE;
    if (s1Valid && s1Write) begin
      if (sigMatch) begin
        strb.wrEn   = 1'b1;
        strb.setCls = 1'b1;
      end
    end else if (s1Valid) begin
      strb.report = 1'b1;
      if (sigMatch && curEntry.cls != '0) begin
        strb.status = ST_CLASSIFIED;
      end else if (sigMatch) begin
        strb.wrEn   = 1'b1;
        strb.bump   = 1'b1;
        strb.status = (curEntry.cnt == TRIG_PREV) ? ST_INFER : ST_ACCEPT;
      end else if (slotEmpty || slotStale) begin
        strb.wrEn   = 1'b1;
        strb.claim  = 1'b1;
        strb.bump   = 1'b1;
        strb.status = (TRIG_COUNT == 1) ? ST_INFER : ST_ACCEPT;
      end else begin
        strb.status = ST_COLLIDE;
      end
    end
  end
endmodule

// File: rtl/flow_dp.sv
module flow_dp
  import flow_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [TUPLE_W-1:0] reqTuple,
  input  logic [TIME_W-1:0]  reqTime,
  input  logic [CLS_W-1:0]   reqClass,
  input  strobe_t            strb,
  output logic               s1Valid,
  output logic               s1Write,
  output logic [SIG_W-1:0]   s1Sig,
  output logic [TIME_W-1:0]  s1Time,
  output entry_t             curEntry,
  output logic               resValid,
  output logic [2:0]         resStatus,
  output logic [CNT_W-1:0]   resCount,
  output logic [CLS_W-1:0]   resClass
);
  localparam int DEPTH = 1 << IDX_W;

  entry_t slotQ [DEPTH];

  logic [SIG_W-1:0] sigIn;
  logic [15:0]      crcIdx;
  logic [IDX_W-1:0] idxIn;
  logic [IDX_W-1:0] s1Idx;
  logic [CLS_W-1:0] s1Class;
  entry_t           rdEntry, fwdEntry, entryNext;
  logic             fwdHit;

  always_comb begin
    sigIn  = crc32Tuple(reqTuple);
    crcIdx = crc16Tuple(reqTuple);
    idxIn  = crcIdx[IDX_W-1:0];
  end

  // stage 1: hash, registered read, forwarding capture
  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid  <= 1'b0;
      s1Write  <= 1'b0;
      s1Sig    <= '0;
      s1Idx    <= '0;
      s1Time   <= '0;
      s1Class  <= '0;
      rdEntry  <= '0;
      fwdHit   <= 1'b0;
      fwdEntry <= '0;
    end else begin
      s1Valid  <= reqValid;
      s1Write  <= reqWrite;
      s1Sig    <= sigIn;
      s1Idx    <= idxIn;
      s1Time   <= reqTime;
      s1Class  <= reqClass;
      rdEntry  <= slotQ[idxIn];
      fwdHit   <= strb.wrEn && (s1Idx == idxIn);
      fwdEntry <= entryNext;
    end
  end

  assign curEntry = fwdHit ? fwdEntry : rdEntry;

  // stage 2: modify
  always_comb begin
    entryNext = curEntry;
    if (strb.claim) begin
      entryNext.sig = s1Sig;
      entryNext.cls = '0;
      entryNext.cnt = '0;
    end
    if (strb.bump) begin
      if (entryNext.cnt != '1) entryNext.cnt = entryNext.cnt + 1'b1;
      entryNext.stamp = s1Time;
    end
    if (strb.setCls) entryNext.cls = s1Class;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) slotQ[i] <= '0;
    end else if (strb.wrEn) begin
      slotQ[s1Idx] <= entryNext;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid  <= 1'b0;
      resStatus <= '0;
      resCount  <= '0;
      resClass  <= '0;
    end else begin
      resValid  <= strb.report;
      resStatus <= strb.status;
      if (strb.report && strb.status != ST_COLLIDE) begin
        resCount <= entryNext.cnt;
        resClass <= entryNext.cls;
      end else begin
        resCount <= '0;
        resClass <= '0;
      end
    end
  end
endmodule

// File: rtl/flow_tracker.sv
module flow_tracker #(
  parameter int          IDX_W      = 4,
  parameter int unsigned IDLE_TICKS = 60,
  parameter int unsigned TRIG_COUNT = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic [103:0] reqTuple,
  input  logic [31:0]  reqTime,
  input  logic [7:0]   reqClass,
  output logic         resValid,
  output logic [2:0]   resStatus,
  output logic [7:0]   resCount,
  output logic [7:0]   resClass
);
  import flow_pkg::*;

  strobe_t     strb;
  logic        s1Valid, s1Write;
  logic [31:0] s1Sig, s1Time;
  entry_t      curEntry;

  flow_dp #(.IDX_W(IDX_W)) u_dp (
    .clk(clk), .rst(rst),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqTuple(reqTuple),
    .reqTime(reqTime), .reqClass(reqClass), .strb(strb),
    .s1Valid(s1Valid), .s1Write(s1Write), .s1Sig(s1Sig), .s1Time(s1Time),
    .curEntry(curEntry),
    .resValid(resValid), .resStatus(resStatus),
    .resCount(resCount), .resClass(resClass)
  );

  flow_ctrl #(.IDLE_TICKS(IDLE_TICKS), .TRIG_COUNT(TRIG_COUNT)) u_ctrl (
    .s1Valid(s1Valid), .s1Write(s1Write), .s1Sig(s1Sig), .s1Time(s1Time),
    .curEntry(curEntry), .strb(strb)
  );
endmodule

// File: rtl/flow_tracker_chk.sv
module flow_tracker_chk #(
  parameter int unsigned TRIG_COUNT = 3
) (
  input logic       clk,
  input logic       rst,
  input logic       reqValid,
  input logic       reqWrite,
  input logic       resValid,
  input logic [2:0] resStatus,
  input logic [7:0] resCount,
  input logic [7:0] resClass
);
  assert_result_origin_R10: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(reqValid && !reqWrite, 2));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !resValid |-> (resStatus == 3'd0 && resCount == 8'd0));

  assert_wb_silent_R7: assert property (@(posedge clk) disable iff (rst)
    $past(reqValid && reqWrite, 2) |-> !resValid);

  assert_collide_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (resValid && resStatus == 3'd3) |-> (resCount == 8'd0 && resClass == 8'd0));

  assert_infer_count_R4: assert property (@(posedge clk) disable iff (rst)
    (resValid && resStatus == 3'd2) |-> resCount == 8'(TRIG_COUNT));

  assert_accept_shape_R2: assert property (@(posedge clk) disable iff (rst)
    (resValid && resStatus == 3'd1) |->
      (resClass == 8'd0 && resCount != 8'd0 && resCount != 8'(TRIG_COUNT)));

  assert_classified_class_R7: assert property (@(posedge clk) disable iff (rst)
    (resValid && resStatus == 3'd4) |-> resClass != 8'd0);

  assert_status_legal_R10: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (resStatus >= 3'd1 && resStatus <= 3'd4));
endmodule

bind flow_tracker flow_tracker_chk #(.TRIG_COUNT(TRIG_COUNT)) u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
  .resValid(resValid), .resStatus(resStatus),
  .resCount(resCount), .resClass(resClass)
);

// File: tb/flow_tracker_tb.sv
`timescale 1ns/1ps
module flow_tracker_tb;
  localparam int IDX_W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic         reqValid, reqWrite;
  logic [103:0] reqTuple;
  logic [31:0]  reqTime;
  logic [7:0]   reqClass;
  logic         resValid;
  logic [2:0]   resStatus;
  logic [7:0]   resCount, resClass;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  flow_tracker #(.IDX_W(IDX_W), .IDLE_TICKS(60), .TRIG_COUNT(3)) u_dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqTuple(reqTuple), .reqTime(reqTime), .reqClass(reqClass),
    .resValid(resValid), .resStatus(resStatus),
    .resCount(resCount), .resClass(resClass)
  );

  // reference hashes, bit-serial
  function automatic logic [31:0] refSig(input logic [103:0] t);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic fb;
    for (int b = 12; b >= 0; b--)
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ t[b*8 + k];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return ~c;
  endfunction

  function automatic logic [IDX_W-1:0] refIdx(input logic [103:0] t);
    logic [15:0] c = 16'h0000;
    logic fb;
    for (int b = 12; b >= 0; b--)
      for (int k = 0; k < 8; k++) begin
        fb = c[0] ^ t[b*8 + k];
        c = c >> 1;
        if (fb) c = c ^ 16'hA001;
      end
    return c[IDX_W-1:0];
  endfunction

  function automatic logic [103:0] mkTuple(input logic [15:0] sp);
    return {32'h0A00_0001, 32'hC0A8_0102, sp, 16'd443, 8'd6};
  endfunction

  // tuple sharing a slot with base but with another signature
  function automatic logic [103:0] sameSlot(input logic [103:0] base);
    logic [103:0] t;
    for (int sp = 1; sp < 4000; sp++) begin
      t = mkTuple(16'(sp));
      if (t != base && refIdx(t) == refIdx(base) && refSig(t) != refSig(base)) return t;
    end
    return base;
  endfunction

  function automatic logic [103:0] otherSlot(input logic [103:0] base);
    logic [103:0] t;
    for (int sp = 1; sp < 4000; sp++) begin
      t = mkTuple(16'(sp));
      if (refIdx(t) != refIdx(base)) return t;
    end
    return base;
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chkRes(input string req, input int st, input int cnt, input int cls);
    chk(req, "resValid", int'(resValid), 1);
    chk(req, "resStatus", int'(resStatus), st);
    chk(req, "resCount", int'(resCount), cnt);
    chk(req, "resClass", int'(resClass), cls);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; reqValid = 1'b0; reqWrite = 1'b0;
    reqTuple = '0; reqTime = '0; reqClass = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // drives at a negedge, samples the result two edges later
  task automatic req(input logic [103:0] t, input int tm, input logic wr, input int cls);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqTuple = t; reqTime = 32'(tm); reqClass = 8'(cls);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [103:0] a = mkTuple(16'd1000);
    doReset();
    @(negedge clk);
    chk("R10", "resValid after reset", int'(resValid), 0);
    chk("R10", "resStatus after reset", int'(resStatus), 0);
    req(a, 5, 1'b0, 0);
    chkRes("R10", 1, 1, 0);
  endtask

  task automatic testCount();
    logic [103:0] a = mkTuple(16'd2000);
    logic [103:0] b;
    doReset();
    b = otherSlot(a);
    req(a, 10, 1'b0, 0); chkRes("R2", 1, 1, 0);
    req(b, 11, 1'b0, 0); chkRes("R1", 1, 1, 0);
    req(a, 12, 1'b0, 0); chkRes("R2", 1, 2, 0);
    req(a, 13, 1'b0, 0); chkRes("R4", 2, 3, 0);
    req(a, 14, 1'b0, 0); chkRes("R4", 1, 4, 0);
  endtask

  task automatic testCollide();
    logic [103:0] a = mkTuple(16'd3000);
    logic [103:0] b;
    doReset();
    b = sameSlot(a);
    req(a, 100, 1'b0, 0); chkRes("R5", 1, 1, 0);
    req(b, 150, 1'b0, 0); chkRes("R1", 3, 0, 0);
    chk("R5", "collide leaves no valid class", int'(resClass), 0);
    req(a, 160, 1'b0, 0); chkRes("R5", 1, 2, 0);
  endtask

  task automatic testEvict();
    logic [103:0] a = mkTuple(16'd4000);
    logic [103:0] b;
    doReset();
    b = sameSlot(a);
    req(a, 0, 1'b0, 0);   chkRes("R6", 1, 1, 0);
    req(a, 100, 1'b0, 0); chkRes("R11", 1, 2, 0);
    req(b, 160, 1'b0, 0); chkRes("R11", 3, 0, 0);
    req(b, 161, 1'b0, 0); chkRes("R6", 1, 1, 0);
    req(a, 162, 1'b0, 0); chkRes("R6", 3, 0, 0);
    req(b, 163, 1'b0, 0); chkRes("R6", 1, 2, 0);
  endtask

  task automatic testWriteBack();
    logic [103:0] a = mkTuple(16'd5000);
    doReset();
    req(a, 1, 1'b0, 0); chkRes("R7", 1, 1, 0);
    req(a, 2, 1'b0, 0); chkRes("R7", 1, 2, 0);
    req(a, 3, 1'b1, 7);
    chk("R7", "no result for write-back", int'(resValid), 0);
    req(a, 4, 1'b0, 0); chkRes("R7", 4, 2, 7);
    req(a, 5, 1'b0, 0); chkRes("R7", 4, 2, 7);
  endtask

  task automatic testWbIgnored();
    logic [103:0] a = mkTuple(16'd6000);
    logic [103:0] b, c;
    doReset();
    b = sameSlot(a);
    c = otherSlot(a);
    req(a, 1, 1'b0, 0); chkRes("R8", 1, 1, 0);
    req(b, 2, 1'b1, 9);
    chk("R8", "no result for write-back", int'(resValid), 0);
    req(a, 3, 1'b0, 0); chkRes("R8", 1, 2, 0);
    req(c, 4, 1'b1, 5);
    req(c, 5, 1'b0, 0); chkRes("R8", 1, 1, 0);
  endtask

  task automatic testBackToBack();
    logic [103:0] a = mkTuple(16'd7000);
    doReset();
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqTuple = a; reqTime = 32'd20;
    @(negedge clk);
    reqTime = 32'd21;
    @(negedge clk);
    reqTime = 32'd22;
    chkRes("R9", 1, 1, 0);
    @(negedge clk);
    reqValid = 1'b0;
    chkRes("R9", 1, 2, 0);
    @(negedge clk);
    chkRes("R9", 2, 3, 0);
    @(negedge clk);
    chk("R10", "resValid drops", int'(resValid), 0);
  endtask

  task automatic testSaturate();
    logic [103:0] a = mkTuple(16'd8000);
    doReset();
    for (int i = 1; i <= 254; i++) req(a, i, 1'b0, 0);
    chk("R3", "count before limit", int'(resCount), 254);
    req(a, 300, 1'b0, 0); chkRes("R3", 1, 255, 0);
    req(a, 301, 1'b0, 0); chkRes("R3", 1, 255, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; reqValid = 1'b0; reqWrite = 1'b0;
    reqTuple = '0; reqTime = '0; reqClass = '0;
    testReset();
    testCount();
    testCollide();
    testEvict();
    testWriteBack();
    testWbIgnored();
    testBackToBack();
    testSaturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule